// File: doc/BRIEF.md
# Per-Channel Vector Symbol Decoder with Window Compare

This block sits on one tester channel. Each vector cycle it takes a 4-bit symbol and turns it into three things: whether the channel driver is on, the level it drives, and what the comparator should see. The symbol set includes two symbols that refer to history. One repeats the last real symbol. The other applies the inverse partner of the last real symbol.

During the vector, the two comparator flags are sampled once, on the first cycle in which the strobe window is open. The flags report "above high threshold" and "below low threshold". The sample is checked against the decoded expectation, which can be a high level, a low level, a valid level or an invalid (mid-band) level. The result is a fail flag and one record bit. The meaning of the record bit depends on the record mode.

A collect-CRC symbol only raises a marker for downstream logic.

Top module: `pin_vec_decode`

## Requirements
- R1: Symbol codes are 0:'1', 1:'0', 2:'h', 3:'l', 4:'H', 5:'L', 6:'Z', 7:'/', 8:'\', 9:'V', 10:'B', 11:'R', 12:'I', 13:'C'. On the clock edge where `vec_strobe` is high, the resolved symbol is registered. From the next cycle, `drive_en`=1 for '1','0','h','l','/','\'. `drive_val` is 1 for '1','h','\' and 0 for '0','l','/'.
- R2: For 'H','L','Z','V','B','C', `drive_en`=0 and `drive_val`=0.
- R3: `expect_active` is 1 for 'h','l','H','L','/','\','V','B' and 0 for '1','0','Z','C'.
- R4: A compare is a mismatch when the expectation is not met. 'h','H' and '/' expect `cmp_hi`=1. 'l','L' and '\' expect `cmp_lo`=1.
- R5: 'V' expects `cmp_hi` OR `cmp_lo`. 'B' expects neither flag set.
- R6: 'R' resolves to the last received symbol that was neither 'R' nor 'I'.
- R7: 'I' resolves to the partner of that last real symbol. The pairs are 1↔0, h↔l, H↔L, /↔\, V↔B. 'Z' and 'C' map to themselves.
- R8: After reset all outputs are 0 and the remembered symbol is 'Z'. An 'R' or 'I' before any real symbol therefore acts as 'Z'.
- R9: Codes 14 and 15 act as 'Z', and they are remembered as 'Z'.
- R10: `crc_mark` is 1 exactly while the resolved symbol is 'C'.
- R11: Within a vector, only the first cycle after the strobe cycle with `win_valid`=1 samples the comparators. A window on the strobe cycle itself is ignored, and so are later windows in the same vector. `fail` is set on the cycle after the sample when a compare is active and mismatched. `fail` holds until the next strobe clears it.
- R12: `rec_mode` is 0 or 3 for no record, 1 for response and 2 for error. On the cycle after the sample, `record_we` pulses for one cycle unless the mode is no-record. `record_bit` is `cmp_hi` in response mode and the fail result in error mode. `record_bit` holds between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_strobe | input | 1 | First cycle of a vector; `op_code` valid |
| op_code | input | 4 | Symbol code |
| win_valid | input | 1 | Strobe window open |
| cmp_hi | input | 1 | Pin above high threshold |
| cmp_lo | input | 1 | Pin below low threshold |
| rec_mode | input | 2 | Record mode |
| drive_en | output | 1 | Driver enable |
| drive_val | output | 1 | Drive level |
| expect_active | output | 1 | A compare applies to this vector |
| fail | output | 1 | Compare mismatch in this vector |
| record_bit | output | 1 | Record data |
| record_we | output | 1 | Record write pulse |
| crc_mark | output | 1 | Channel marked for CRC collection |

## Verification
The hardest state to reach is a history symbol whose meaning depends on an earlier vector. This includes an 'I' that follows several 'R' symbols, and an 'R' or 'I' arriving before any real symbol after reset. The stimulus opens with history symbols straight after reset. It then walks every code, including 14 and 15, each followed by both 'R' and 'I', under all comparator combinations and record modes. Some vectors also open the window on the strobe cycle or open it twice, which exercises the once-per-vector sampling.

// File: rtl/pin_vec_decode.sv
module pin_vec_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vec_strobe,
  input  logic [3:0] op_code,
  input  logic       win_valid,
  input  logic       cmp_hi,
  input  logic       cmp_lo,
  input  logic [1:0] rec_mode,
  output logic       drive_en,
  output logic       drive_val,
  output logic       expect_active,
  output logic       fail,
  output logic       record_bit,
  output logic       record_we,
  output logic       crc_mark
);
  localparam logic [3:0] OP_D1 = 4'd0, OP_D0 = 4'd1, OP_DH = 4'd2, OP_DL = 4'd3;
  localparam logic [3:0] OP_EH = 4'd4, OP_EL = 4'd5, OP_Z = 4'd6, OP_LH = 4'd7;
  localparam logic [3:0] OP_HL = 4'd8, OP_V = 4'd9, OP_B = 4'd10, OP_R = 4'd11;
  localparam logic [3:0] OP_I = 4'd12, OP_C = 4'd13;
  localparam logic [1:0] RM_RESP = 2'd1, RM_ERR = 2'd2;

  typedef enum logic [2:0] {EX_NONE, EX_HI, EX_LO, EX_VALID, EX_INVALID} exp_t;

  function automatic logic [3:0] partner(input logic [3:0] c);
    case (c)
      OP_D1: partner = OP_D0;
      OP_D0: partner = OP_D1;
      OP_DH: partner = OP_DL;
      OP_DL: partner = OP_DH;
      OP_EH: partner = OP_EL;
      OP_EL: partner = OP_EH;
      OP_LH: partner = OP_HL;
      OP_HL: partner = OP_LH;
      OP_V:  partner = OP_B;
      OP_B:  partner = OP_V;
      default: partner = c;
    endcase
  endfunction

  logic [3:0] last_real, norm_op, eff_op;
  logic       d_en, d_val, d_crc;
  exp_t       d_exp, exp_q;
  logic       active, sampled, mismatch, take;

  assign norm_op = (op_code > OP_C) ? OP_Z : op_code;
  assign eff_op  = (op_code == OP_R) ? last_real :
                   (op_code == OP_I) ? partner(last_real) : norm_op;

  always_comb begin
    d_en = 1'b0; d_val = 1'b0; d_exp = EX_NONE; d_crc = 1'b0;
    case (eff_op)
      OP_D1: begin d_en = 1'b1; d_val = 1'b1; end
      OP_D0: d_en = 1'b1;
      OP_DH: begin d_en = 1'b1; d_val = 1'b1; d_exp = EX_HI; end
      OP_DL: begin d_en = 1'b1; d_exp = EX_LO; end
      OP_EH: d_exp = EX_HI;
      OP_EL: d_exp = EX_LO;
      OP_LH: begin d_en = 1'b1; d_exp = EX_HI; end
      OP_HL: begin d_en = 1'b1; d_val = 1'b1; d_exp = EX_LO; end
      OP_V:  d_exp = EX_VALID;
      OP_B:  d_exp = EX_INVALID;
      OP_C:  d_crc = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (exp_q)
      EX_HI:      mismatch = !cmp_hi;
      EX_LO:      mismatch = !cmp_lo;
      EX_VALID:   mismatch = !(cmp_hi || cmp_lo);
      EX_INVALID: mismatch = cmp_hi || cmp_lo;
      default:    mismatch = 1'b0;
    endcase
  end

  assign take = active && win_valid && !sampled && !vec_strobe;
  assign expect_active = (exp_q != EX_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_real  <= OP_Z;
      drive_en   <= 1'b0;
      drive_val  <= 1'b0;
      exp_q      <= EX_NONE;
      crc_mark   <= 1'b0;
      active     <= 1'b0;
      sampled    <= 1'b0;
      fail       <= 1'b0;
      record_bit <= 1'b0;
      record_we  <= 1'b0;
    end else begin
      record_we <= 1'b0;
      if (vec_strobe) begin
        if (op_code != OP_R && op_code != OP_I) last_real <= norm_op;
        drive_en  <= d_en;
        drive_val <= d_val;
        exp_q     <= d_exp;
        crc_mark  <= d_crc;
        active    <= 1'b1;
        sampled   <= 1'b0;
        fail      <= 1'b0;
      end else if (take) begin
        sampled    <= 1'b1;
        fail       <= mismatch;
        record_bit <= (rec_mode == RM_RESP) ? cmp_hi : mismatch;
        record_we  <= (rec_mode == RM_RESP) || (rec_mode == RM_ERR);
      end
    end
  end
endmodule

module pin_vec_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       win_valid,
  input logic [1:0] rec_mode,
  input logic       drive_en,
  input logic       drive_val,
  input logic       expect_active,
  input logic       fail,
  input logic       record_bit,
  input logic       record_we,
  input logic       crc_mark
);
  assert_off_level_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !drive_val);
  assert_crc_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_mark |-> (!drive_en && !expect_active));
  assert_fail_needs_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(win_valid) && expect_active));
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    record_we |=> !record_we);
  assert_write_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    record_we |-> ($past(rec_mode) == 2'd1 || $past(rec_mode) == 2'd2));
  assert_err_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (record_we && $past(rec_mode) == 2'd2) |-> (record_bit == fail));
endmodule

bind pin_vec_decode pin_vec_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .rec_mode(rec_mode),
  .drive_en(drive_en), .drive_val(drive_val), .expect_active(expect_active),
  .fail(fail), .record_bit(record_bit), .record_we(record_we), .crc_mark(crc_mark)
);

// File: tb/pin_vec_decode_bench.sv
module pin_vec_decode_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_strobe = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic win_valid = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic [1:0] rec_mode = 2'd0;
  logic drive_en, drive_val, expect_active, fail, record_bit, record_we, crc_mark;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_vec_decode u_pin_vec_decode (
    .clk(clk), .rst_n(rst_n), .vec_strobe(vec_strobe), .op_code(op_code),
    .win_valid(win_valid), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .rec_mode(rec_mode),
    .drive_en(drive_en), .drive_val(drive_val), .expect_active(expect_active),
    .fail(fail), .record_bit(record_bit), .record_we(record_we), .crc_mark(crc_mark)
  );

  // reference model: symbols handled as characters
  string sym = "10hlHLZ/\\VBRIC";
  byte   m_last = "Z";
  byte   m_cur  = "Z";
  bit    m_en, m_val, m_exp, m_fail, m_bit, m_we, m_crc, m_act, m_smp;
  string m_tag = "R8";

  function automatic byte to_char(input int c);
    return (c >= 14) ? byte'("Z") : sym[c];
  endfunction

  function automatic byte flip(input byte s);
    case (s)
      "1": return "0"; "0": return "1";
      "h": return "l"; "l": return "h";
      "H": return "L"; "L": return "H";
      "/": return "\\"; "\\": return "/";
      "V": return "B"; "B": return "V";
      default: return s;
    endcase
  endfunction

  function automatic bit is_bad(input byte s, input bit hi, input bit lo);
    case (s)
      "h", "H", "/": return !hi;
      "l", "L", "\\": return !lo;
      "V": return !(hi | lo);
      "B": return hi | lo;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = "Z"; m_cur = "Z"; m_en = 0; m_val = 0; m_exp = 0; m_fail = 0;
      m_bit = 0; m_we = 0; m_crc = 0; m_act = 0; m_smp = 0; m_tag = "R8";
    end else begin
      m_we = 0;
      if (vec_strobe) begin
        byte c;
        c = to_char(int'(op_code));
        if (c == "R") begin m_cur = m_last; m_tag = "R6"; end
        else if (c == "I") begin m_cur = flip(m_last); m_tag = "R7"; end
        else begin
          m_cur = c; m_last = c;
          m_tag = (op_code >= 14) ? "R9" : (c == "C") ? "R10" :
                  (c == "V" || c == "B") ? "R5" : "R1";
        end
        m_en  = (m_cur == "1" || m_cur == "0" || m_cur == "h" || m_cur == "l" ||
                 m_cur == "/" || m_cur == "\\");
        m_val = (m_cur == "1" || m_cur == "h" || m_cur == "\\");
        m_exp = (m_cur == "h" || m_cur == "l" || m_cur == "H" || m_cur == "L" ||
                 m_cur == "/" || m_cur == "\\" || m_cur == "V" || m_cur == "B");
        m_crc = (m_cur == "C");
        m_act = 1; m_smp = 0; m_fail = 0;
      end else if (m_act && win_valid && !m_smp) begin
        m_smp = 1;
        m_fail = is_bad(m_cur, cmp_hi, cmp_lo);
        m_bit = (rec_mode == 1) ? cmp_hi : m_fail;
        m_we = (rec_mode == 1 || rec_mode == 2);
      end
    end
  end

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_tag == "R1" && !m_en ? "R2" : m_tag, "drive_en", drive_en, m_en);
      chk(m_tag, "drive_val", drive_val, m_val);
      chk("R3", "expect_active", expect_active, m_exp);
      chk(m_smp ? (m_cur == "V" || m_cur == "B" ? "R5" : "R4") : "R11", "fail", fail, m_fail);
      chk("R12", "record_we", record_we, m_we);
      chk("R12", "record_bit", record_bit, m_bit);
      chk("R10", "crc_mark", crc_mark, m_crc);
    end
  end

  task automatic vec(input int code, input int mode, input bit hi, input bit lo,
                     input bit early_win, input bit twice);
    @(negedge clk);
    vec_strobe = 1; op_code = 4'(code); rec_mode = 2'(mode);
    win_valid = early_win; cmp_hi = !hi; cmp_lo = !lo;
    @(negedge clk);
    vec_strobe = 0; win_valid = 0;
    @(negedge clk);
    win_valid = 1; cmp_hi = hi; cmp_lo = lo;
    @(negedge clk);
    win_valid = twice; cmp_hi = !hi; cmp_lo = !lo;
    @(negedge clk);
    win_valid = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "drive_en reset", drive_en, 0);
    chk("R8", "fail reset", fail, 0);
    chk("R8", "record_we reset", record_we, 0);
    rst_n = 1;
    // R8: history symbols before any real symbol act as Z
    vec(11, 2, 0, 0, 0, 0);
    vec(12, 1, 1, 0, 0, 0);
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 4; k++) begin
          vec(c, m, k[0], k[1], k == 2, k == 1);
          vec(11, m, k[1], k[0], 0, 0);   // R6
          vec(12, (m + 1) % 4, k[0], !k[1], k == 3, 0); // R7
          vec(11, 2, k[0], k[1], 0, 1);
        end
    // R9 remembered as Z, then I keeps Z
    vec(15, 1, 1, 1, 0, 0);
    vec(12, 2, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule